// File: doc/BRIEF.md
# Six-Tick Retractile Stage Sequencer

This block sequences the gate enables for a chain of split-rail, reversible retractile logic stages. A common tick strobe paces all stages. A start pulse asks the first stage to accept a new data wave. Each stage then moves through six ticks. It first drives its forward path and charges its output. It then powers its reverse path. It retracts its input through the reverse transmission gate, and finally releases its output. Each stage runs one tick behind the stage before it, so that a stage's valid output serves as the valid input of the next stage.

The sequencer keeps one phase register per stage. A phase of zero means idle: every gate is off and every node is neutral. Phases one to six are the ticks of the cycle. Stage 0 is launched by the start logic. Every later stage loads its predecessor's phase on each tick.

The block contains a node checker. It derives a logic level for each input, output and gate-output node from the enables. It raises a sticky flag if a transmission gate is open across two nodes at different levels, or if a stage's input disagrees with the output that feeds it. A start that cannot be accepted is dropped and counted.

Top module: `retract_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) returns every stage to idle. After that edge, all enable outputs are 0, `overrun_cnt` is 0 and `node_err` is 0.
- R2: A start is accepted when stage 0 is idle and no launch is waiting. The accepted start launches at the first clock edge, in that cycle or a later one, where `tick` is high. After that edge, stage 0 is in phase 1, with `stg_in_valid[0]` and `stg_fwd_open[0]` high.
- R3: Stage 0 advances exactly one phase, 1 through 6, at each edge where `tick` is high. From phase 6 it returns to idle. With `tick` low, no stage changes.
- R4: The enables decode from the phase as follows. Input-valid is high in phases 1 to 4. Forward gate open is high in phases 1 to 2. Forward gate powered is high in phases 2 to 3. Reverse gate powered is high in phases 3 to 4. Reverse gate open is high in phases 4 to 5. Output-valid is high in phases 2 to 5. In idle and in phase 6, all enables are low.
- R5: At every edge with `tick` high, stage k (k ≥ 1) takes the phase that stage k-1 held before that edge. The enables of stage k therefore repeat those of stage k-1 one tick later.
- R6: A start that arrives while stage 0 is not idle, or while a launch is already waiting, has no effect on the stages. Such a start increments `overrun_cnt` by one, and the counter saturates at its all-ones value.
- R7: `node_err` becomes high and stays high until reset when any of these holds: a forward gate is open while the forward-gate level differs from the output level, a reverse gate is open while the reverse-gate level differs from the input level, or a stage's input-valid differs from the previous stage's output-valid. Under the sequencing above it stays 0.
- R8: A start that arrives in the same cycle as the tick that moves stage 0 from phase 6 to idle counts as an overrun. A start in any later cycle with stage 0 idle is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Tick strobe, one clock wide per tick |
| start | input | 1 | Request to launch a new wave into stage 0 |
| stg_in_valid | output | N_STAGES | Per-stage input-valid |
| stg_fwd_open | output | N_STAGES | Per-stage forward transmission gate open |
| stg_fwd_pwr | output | N_STAGES | Per-stage forward gate powered |
| stg_rev_pwr | output | N_STAGES | Per-stage reverse gate powered |
| stg_rev_open | output | N_STAGES | Per-stage reverse transmission gate open |
| stg_out_valid | output | N_STAGES | Per-stage output-valid |
| overrun_cnt | output | OVR_W | Saturating count of rejected starts |
| node_err | output | 1 | Sticky node-level mismatch flag |

## Verification
A start and a tick can fall in the same cycle. When stage 0 is idle, this must launch the wave at once. When the tick is the one that retires stage 0 from phase 6, it must be refused as an overrun, even though the stage is idle after that edge. Directed steps pair `start` with exactly those ticks, and random stimulus pairs them often. Every cycle, a bench model built from the requirements decides whether the stages launched and whether the counter moved.

// File: rtl/retract_pkg.sv
`timescale 1ns/1ps
package retract_pkg;

  localparam int PH_W = 3;
  typedef logic [PH_W-1:0] phase_t;

  localparam phase_t PH_IDLE  = 3'd0;
  localparam phase_t PH_FIRST = 3'd1;
  localparam phase_t PH_LAST  = 3'd6;

  typedef struct packed {
    logic in_valid;
    logic fwd_open;
    logic fwd_pwr;
    logic rev_pwr;
    logic rev_open;
    logic out_valid;
  } gate_en_t;

  // Enable set held during each phase of the six-tick cycle.
  function automatic gate_en_t phase_to_en(phase_t p);
    gate_en_t e;
    e = '0;
    case (p)
      3'd1: begin
        e.in_valid = 1'b1;
        e.fwd_open = 1'b1;
      end
      3'd2: begin
        e.in_valid  = 1'b1;
        e.fwd_open  = 1'b1;
        e.fwd_pwr   = 1'b1;
        e.out_valid = 1'b1;
      end
      3'd3: begin
        e.in_valid  = 1'b1;
        e.fwd_pwr   = 1'b1;
        e.rev_pwr   = 1'b1;
        e.out_valid = 1'b1;
      end
      3'd4: begin
        e.in_valid  = 1'b1;
        e.rev_pwr   = 1'b1;
        e.rev_open  = 1'b1;
        e.out_valid = 1'b1;
      end
      3'd5: begin
        e.rev_open  = 1'b1;
        e.out_valid = 1'b1;
      end
      default: e = '0;
    endcase
    return e;
  endfunction

  // Phase after one tick for a running stage; the last phase retires to idle.
  function automatic phase_t phase_step(phase_t p);
    if (p == PH_IDLE || p == PH_LAST) return PH_IDLE;
    return p + PH_FIRST;
  endfunction

endpackage

// File: rtl/retract_launch.sv
`timescale 1ns/1ps
module retract_launch
  import retract_pkg::*;
#(
  parameter int OVR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             start,
  input  phase_t           phase0,
  output phase_t           load0,
  output logic             launch,
  output logic             ovr_evt,
  output logic [OVR_W-1:0] ovr_cnt
);

  localparam logic [OVR_W-1:0] CNT_MAX = {OVR_W{1'b1}};

  logic pend_q;
  logic idle0;
  logic accept;

  assign idle0   = (phase0 == PH_IDLE);
  assign accept  = idle0 && !pend_q;
  assign ovr_evt = start && !accept;
  assign launch  = tick && idle0 && (pend_q || start);

  always_comb begin
    if (idle0) load0 = launch ? PH_FIRST : PH_IDLE;
    else       load0 = phase_step(phase0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
    end else if (launch) begin
      pend_q <= 1'b0;
    end else if (start && accept) begin
      pend_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_cnt <= '0;
    end else if (ovr_evt && ovr_cnt != CNT_MAX) begin
      ovr_cnt <= ovr_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/retract_stage.sv
`timescale 1ns/1ps
module retract_stage
  import retract_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  phase_t   load_phase,
  output phase_t   phase,
  output gate_en_t en
);

  always_ff @(posedge clk) begin
    if (rst)       phase <= PH_IDLE;
    else if (tick) phase <= load_phase;
  end

  assign en = phase_to_en(phase);

endmodule

// File: rtl/retract_node_chk.sv
`timescale 1ns/1ps
module retract_node_chk #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] in_lvl,
  input  logic [N-1:0] fwd_open,
  input  logic [N-1:0] fwd_lvl,
  input  logic [N-1:0] rev_lvl,
  input  logic [N-1:0] rev_open,
  input  logic [N-1:0] out_lvl,
  output logic         node_err
);

  logic [N-1:0] fault;

  for (genvar k = 0; k < N; k++) begin : g_node
    logic link_bad;
    if (k == 0) begin : g_head
      assign link_bad = 1'b0;
    end else begin : g_link
      assign link_bad = (in_lvl[k] != out_lvl[k-1]);
    end
    assign fault[k] = (fwd_open[k] && (fwd_lvl[k] != out_lvl[k]))
                   || (rev_open[k] && (rev_lvl[k] != in_lvl[k]))
                   || link_bad;
  end

  always_ff @(posedge clk) begin
    if (rst)         node_err <= 1'b0;
    else if (|fault) node_err <= 1'b1;
  end

endmodule

// File: rtl/retract_seq.sv
`timescale 1ns/1ps
module retract_seq
  import retract_pkg::*;
#(
  parameter int N_STAGES = 4,
  parameter int OVR_W    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                start,
  output logic [N_STAGES-1:0] stg_in_valid,
  output logic [N_STAGES-1:0] stg_fwd_open,
  output logic [N_STAGES-1:0] stg_fwd_pwr,
  output logic [N_STAGES-1:0] stg_rev_pwr,
  output logic [N_STAGES-1:0] stg_rev_open,
  output logic [N_STAGES-1:0] stg_out_valid,
  output logic [OVR_W-1:0]    overrun_cnt,
  output logic                node_err
);

  phase_t   ph   [N_STAGES];
  phase_t   load [N_STAGES];
  gate_en_t en   [N_STAGES];

  logic   launch;
  logic   ovr_evt;
  phase_t load0;

  retract_launch #(.OVR_W(OVR_W)) u_launch (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .start   (start),
    .phase0  (ph[0]),
    .load0   (load0),
    .launch  (launch),
    .ovr_evt (ovr_evt),
    .ovr_cnt (overrun_cnt)
  );

  for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
    if (k == 0) begin : g_first
      assign load[k] = load0;
    end else begin : g_follow
      assign load[k] = ph[k-1];
    end

    retract_stage u_stage (
      .clk        (clk),
      .rst        (rst),
      .tick       (tick),
      .load_phase (load[k]),
      .phase      (ph[k]),
      .en         (en[k])
    );

    assign stg_in_valid[k]  = en[k].in_valid;
    assign stg_fwd_open[k]  = en[k].fwd_open;
    assign stg_fwd_pwr[k]   = en[k].fwd_pwr;
    assign stg_rev_pwr[k]   = en[k].rev_pwr;
    assign stg_rev_open[k]  = en[k].rev_open;
    assign stg_out_valid[k] = en[k].out_valid;
  end

  retract_node_chk #(.N(N_STAGES)) u_nodes (
    .clk      (clk),
    .rst      (rst),
    .in_lvl   (stg_in_valid),
    .fwd_open (stg_fwd_open),
    .fwd_lvl  (stg_fwd_pwr),
    .rev_lvl  (stg_rev_pwr),
    .rev_open (stg_rev_open),
    .out_lvl  (stg_out_valid),
    .node_err (node_err)
  );

endmodule

// File: rtl/retract_seq_chk.sv
`timescale 1ns/1ps
module retract_seq_chk #(
  parameter int N     = 4,
  parameter int OVR_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             launch,
  input logic             ovr_evt,
  input logic [N-1:0]     in_valid,
  input logic [N-1:0]     fwd_open,
  input logic [N-1:0]     fwd_pwr,
  input logic [N-1:0]     rev_pwr,
  input logic [N-1:0]     rev_open,
  input logic [N-1:0]     out_valid,
  input logic [OVR_W-1:0] ovr_cnt,
  input logic             node_err
);

  localparam logic [OVR_W-1:0] CNT_MAX = {OVR_W{1'b1}};

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (in_valid == '0 && fwd_open == '0 && out_valid == '0 && ovr_cnt == '0 && !node_err)); // R1

  AST_LAUNCH_PHASE1: assert property (@(posedge clk) disable iff (rst)
    launch |=> (in_valid[0] && fwd_open[0] && !fwd_pwr[0])); // R2

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(in_valid) && $stable(fwd_pwr) && $stable(rev_open) && $stable(out_valid))); // R3

  AST_GATES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    (fwd_open & rev_open) == '0); // R4

  if (N > 1) begin : g_stagger
    AST_STAGGER: assert property (@(posedge clk) disable iff (rst)
      tick |=> (in_valid[N-1:1] == $past(in_valid[N-2:0]) && rev_pwr[N-1:1] == $past(rev_pwr[N-2:0]))); // R5
  end

  AST_OVR_COUNT: assert property (@(posedge clk) disable iff (rst)
    (ovr_evt && ovr_cnt != CNT_MAX) |=> ovr_cnt == $past(ovr_cnt) + 1'b1); // R6

  AST_OVR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ovr_evt |=> $stable(ovr_cnt)); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    node_err |=> node_err); // R7

  AST_NODES_MATCH: assert property (@(posedge clk) disable iff (rst)
    !node_err); // R7

endmodule

bind retract_seq retract_seq_chk #(.N(N_STAGES), .OVR_W(OVR_W)) u_seq_chk (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick),
  .launch    (launch),
  .ovr_evt   (ovr_evt),
  .in_valid  (stg_in_valid),
  .fwd_open  (stg_fwd_open),
  .fwd_pwr   (stg_fwd_pwr),
  .rev_pwr   (stg_rev_pwr),
  .rev_open  (stg_rev_open),
  .out_valid (stg_out_valid),
  .ovr_cnt   (overrun_cnt),
  .node_err  (node_err)
);

// File: tb/test_retract_seq.sv
`timescale 1ns/1ps
module test_retract_seq;

  localparam int N  = 4;
  localparam int CW = 8;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick = 1'b0;
  logic          start = 1'b0;
  logic [N-1:0]  stg_in_valid, stg_fwd_open, stg_fwd_pwr;
  logic [N-1:0]  stg_rev_pwr, stg_rev_open, stg_out_valid;
  logic [CW-1:0] overrun_cnt;
  logic          node_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int m_ph [N];
  bit m_pend;
  int m_cnt;

  always #2.5 clk = ~clk;

  retract_seq #(.N_STAGES(N), .OVR_W(CW)) i_retract_seq (
    .clk           (clk),
    .rst           (rst),
    .tick          (tick),
    .start         (start),
    .stg_in_valid  (stg_in_valid),
    .stg_fwd_open  (stg_fwd_open),
    .stg_fwd_pwr   (stg_fwd_pwr),
    .stg_rev_pwr   (stg_rev_pwr),
    .stg_rev_open  (stg_rev_open),
    .stg_out_valid (stg_out_valid),
    .overrun_cnt   (overrun_cnt),
    .node_err      (node_err)
  );

  // Expected enables {in, fwd_open, fwd_pwr, rev_pwr, rev_open, out} from a phase number.
  function automatic logic [5:0] exp_en(int p);
    logic [5:0] v;
    v[5] = (p >= 1 && p <= 4);
    v[4] = (p == 1 || p == 2);
    v[3] = (p == 2 || p == 3);
    v[2] = (p == 3 || p == 4);
    v[1] = (p == 4 || p == 5);
    v[0] = (p >= 2 && p <= 5);
    return v;
  endfunction

  function automatic logic [5:0] act_en(int k);
    return {stg_in_valid[k], stg_fwd_open[k], stg_fwd_pwr[k],
            stg_rev_pwr[k], stg_rev_open[k], stg_out_valid[k]};
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_edge(bit r, bit t, bit s);
    bit idle0, acc, launch;
    if (r) begin
      foreach (m_ph[k]) m_ph[k] = 0;
      m_pend = 0;
      m_cnt  = 0;
      return;
    end
    idle0  = (m_ph[0] == 0);
    acc    = idle0 && !m_pend;
    launch = t && idle0 && (m_pend || s);
    if (s && !acc && m_cnt < CMAX) m_cnt++;
    if (launch)        m_pend = 0;
    else if (s && acc) m_pend = 1;
    if (t) begin
      for (int k = N - 1; k >= 1; k--) m_ph[k] = m_ph[k-1];
      if (idle0) m_ph[0] = launch ? 1 : 0;
      else       m_ph[0] = (m_ph[0] >= 6) ? 0 : m_ph[0] + 1;
    end
  endtask

  task automatic compare(string tag);
    check(act_en(0) == exp_en(m_ph[0]), tag, "stage0 enables (R3 R4)", act_en(0), exp_en(m_ph[0]));
    for (int k = 1; k < N; k++)
      check(act_en(k) == exp_en(m_ph[k]), "R5", $sformatf("stage%0d enables", k), act_en(k), exp_en(m_ph[k]));
    check(overrun_cnt == CW'(m_cnt), "R6", "overrun count", overrun_cnt, m_cnt);
    check(node_err == 1'b0, "R7", "node mismatch flag", node_err, 0);
  endtask

  // One clock: drive away from the edge, update the model at the edge, sample 1 ns later.
  task automatic cyc(bit t, bit s, bit r, string tag);
    tick = t; start = s; rst = r;
    @(posedge clk);
    model_edge(r, t, s);
    #1;
    compare(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20517));
    #1;
    // R1: reset state
    cyc(0, 0, 1, "R1");
    cyc(0, 0, 1, "R1");
    check(stg_in_valid == '0 && stg_out_valid == '0 && stg_fwd_open == '0 && overrun_cnt == '0,
          "R1", "all idle after reset", {stg_in_valid, stg_out_valid}, 0);

    // R2: start and tick in the same cycle launch at once
    cyc(1, 1, 0, "R2");
    check(stg_in_valid[0] && stg_fwd_open[0], "R2", "stage0 phase1 after start+tick", act_en(0), 6'b110000);
    // R3 R4: step through the six ticks with idle cycles between them
    for (int i = 0; i < 5; i++) begin
      cyc(0, 0, 0, "R3");
      cyc(1, 0, 0, "R4");
    end
    // stage0 now in phase 6; start on its retiring tick is an overrun (R8)
    cyc(1, 1, 0, "R8");
    check(overrun_cnt == 8'd1 && stg_in_valid[0] == 1'b0, "R8", "start on retiring tick dropped",
          overrun_cnt, 1);
    // next cycle start is accepted, waits for a tick (R2)
    cyc(0, 1, 0, "R8");
    cyc(0, 0, 0, "R2");
    check(stg_in_valid[0] == 1'b0, "R2", "no launch before tick", stg_in_valid[0], 0);
    cyc(0, 1, 0, "R6");
    check(overrun_cnt == 8'd2, "R6", "second start while waiting", overrun_cnt, 2);
    cyc(1, 0, 0, "R2");
    check(stg_fwd_open[0] == 1'b1, "R2", "waiting launch taken on tick", stg_fwd_open[0], 1);
    // R6: start mid-cycle ignored
    cyc(1, 0, 0, "R6");
    cyc(0, 1, 0, "R6");
    check(overrun_cnt == 8'd3 && act_en(0) == exp_en(2), "R6", "mid-cycle start ignored",
          {overrun_cnt, act_en(0)}, {8'd3, exp_en(2)});
    // R5: let the wave run through all stages
    for (int i = 0; i < 12; i++) cyc(1, 0, 0, "R5");
    check(stg_in_valid == '0 && stg_out_valid == '0, "R5", "chain drained", stg_out_valid, 0);

    // R6: saturation of the overrun counter
    cyc(1, 1, 0, "R6");
    for (int i = 0; i < 300; i++) cyc(0, 1, 0, "R6");
    check(overrun_cnt == CW'(CMAX), "R6", "overrun saturates", overrun_cnt, CMAX);

    // R1: reset in the middle of a run
    cyc(1, 0, 0, "R1");
    cyc(0, 0, 1, "R1");
    check(stg_in_valid == '0 && overrun_cnt == '0 && node_err == 1'b0, "R1", "mid-run reset",
          {stg_in_valid, overrun_cnt}, 0);

    // Random stimulus
    for (int i = 0; i < 6000; i++) begin
      bit t, s, r;
      t = ($urandom % 2) == 0;
      s = ($urandom % 6) == 0;
      r = ($urandom % 400) == 0;
      cyc(t, s, r, "R3");
    end
    // R7: flag still clear after long legal run
    check(node_err == 1'b0, "R7", "no node mismatch", node_err, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule